// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits between a synchronous host and an asynchronous byte-wide EPROM with a 17-bit address and active-low chip-enable and output-enable strobes. The host offers an address with a valid/ready handshake. The block then drives the address and chip-enable, and asserts output-enable later, after a slack interval. It captures the byte once the access time has passed and returns it with a single-cycle valid pulse. Before it starts the next access, it waits for the memory's outputs to float.

The part's speed is chosen per request through a 2-bit grade input, which is captured at acceptance. Each grade has three independent budgets: address/chip-enable to data, output-enable to data, and output release. Each budget is turned into a cycle count at elaboration from the clock period parameter. Output-enable is held back by the difference between the first two budgets, so the whole access is never longer than the address budget requires.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held low, req_ready is 1, mem_ce_n and mem_oe_n are 1, and rsp_valid is 0.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. mem_ce_n falls and mem_addr takes req_addr on that same edge. req_ready stays 0 from that edge until the output-release interval has expired.
- R3: A delay of t ns becomes floor(t/P)+1 cycles, where P is CLK_PERIOD_NS; the minimum is one cycle. The address-to-data budget by grade code is 0:120, 1:150, 2:200, 3:250 ns. rsp_valid rises A cycles after the accept edge. A is the larger of the converted address budget and (the R4 delay plus the converted output-enable budget).
- R4: mem_oe_n falls floor((tACC−tOE)/P) cycles after the accept edge, and never earlier than one cycle after it. The output-enable budget by grade code is 0:50, 1:60, 2:70, 3:100 ns.
- R5: The data byte is captured on the same edge where mem_oe_n and mem_ce_n return to 1. rsp_data equals the memory byte at the requested address. rsp_valid is high for exactly one cycle per access.
- R6: After mem_oe_n rises, mem_ce_n does not fall again for floor(tDF/P)+1 cycles, where tDF is 40 ns for grade 0 and 50 ns for the other grades. A request already waiting is accepted on exactly that edge.
- R7: The grade is captured at acceptance. A change of the grade input during an access has no effect on that access's timing.
- R8: While mem_ce_n is low, mem_addr holds the accepted address, even if req_addr changes. mem_oe_n is low only while mem_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grade | input | 2 | Speed-grade code of the attached memory |
| req_valid | input | 1 | Host read request valid |
| req_addr | input | 17 | Host read address |
| req_ready | output | 1 | Block can take a request |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds the read byte |
| rsp_data | output | 8 | Byte read from memory |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_data | input | 8 | Data from the memory |

## Verification
The bench uses the default 10 ns clock. At that period every budget is an exact multiple of the period, so the extra margin cycle of the rounding rule appears in every count. All four grades give distinct access lengths (13, 16, 21 and 26 cycles), distinct output-enable points (7, 9, 13 and 15 cycles) and two release lengths (5 and 6 cycles). A behavioural memory drives unknown data until its address, chip-enable and output-enable budgets have all run out. An early capture therefore shows up as a data mismatch. Back-to-back bursts, including bursts that change grade, pin the release interval to its exact edge.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  localparam int GRADE_W  = 2;
  localparam int N_GRADES = 1 << GRADE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } seq_state_e;

  // address / chip-enable to data, ns
  function automatic int grade_acc_ns(input int g);
    case (g)
      0:       return 120;
      1:       return 150;
      2:       return 200;
      default: return 250;
    endcase
  endfunction

  // output-enable to data, ns
  function automatic int grade_oe_ns(input int g);
    case (g)
      0:       return 50;
      1:       return 60;
      2:       return 70;
      default: return 100;
    endcase
  endfunction

  // strobe high to outputs released, ns
  function automatic int grade_float_ns(input int g);
    return (g == 0) ? 40 : 50;
  endfunction

  // smallest cycle count strictly longer than ns
  function automatic int past_cycles(input int ns, input int period);
    return ns / period + 1;
  endfunction

  function automatic int oe_delay_cycles(input int g, input int period);
    int d;
    d = (grade_acc_ns(g) - grade_oe_ns(g)) / period;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int acc_cycles(input int g, input int period);
    int a, b;
    a = past_cycles(grade_acc_ns(g), period);
    b = oe_delay_cycles(g, period) + past_cycles(grade_oe_ns(g), period);
    return (a > b) ? a : b;
  endfunction

  function automatic int float_cycles(input int g, input int period);
    return past_cycles(grade_float_ns(g), period);
  endfunction

  function automatic int max_cycles(input int period);
    int m;
    m = 1;
    for (int g = 0; g < N_GRADES; g++) begin
      if (acc_cycles(g, period) > m)   m = acc_cycles(g, period);
      if (float_cycles(g, period) > m) m = float_cycles(g, period);
    end
    return m;
  endfunction

endpackage

// File: rtl/eprom_grade_timing.sv
`timescale 1ns/1ps
module eprom_grade_timing
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CNT_W         = 5
) (
  input  logic [GRADE_W-1:0] grade,
  output logic [CNT_W-1:0]   oe_dly_cyc,
  output logic [CNT_W-1:0]   acc_cyc,
  output logic [CNT_W-1:0]   float_cyc
);

  logic [CNT_W-1:0] tbl_oe    [N_GRADES];
  logic [CNT_W-1:0] tbl_acc   [N_GRADES];
  logic [CNT_W-1:0] tbl_float [N_GRADES];

  for (genvar g = 0; g < N_GRADES; g++) begin : g_grade
    localparam int OE_D  = oe_delay_cycles(g, CLK_PERIOD_NS);
    localparam int ACC_D = acc_cycles(g, CLK_PERIOD_NS);
    localparam int FLT_D = float_cycles(g, CLK_PERIOD_NS);
    assign tbl_oe[g]    = CNT_W'(OE_D);
    assign tbl_acc[g]   = CNT_W'(ACC_D);
    assign tbl_float[g] = CNT_W'(FLT_D);
  end

  assign oe_dly_cyc = tbl_oe[grade];
  assign acc_cyc    = tbl_acc[grade];
  assign float_cyc  = tbl_float[grade];

endmodule

// File: rtl/eprom_access_seq.sv
`timescale 1ns/1ps
module eprom_access_seq
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [GRADE_W-1:0] grade,
  output logic               req_ready,
  input  logic [CNT_W-1:0]   oe_dly_cyc,
  input  logic [CNT_W-1:0]   acc_cyc,
  input  logic [CNT_W-1:0]   float_cyc,
  output logic [GRADE_W-1:0] grade_q,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               capture_en
);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q;
  logic              oe_n_q;

  // named events
  logic accept;
  logic oe_due;
  logic sample_due;
  logic float_done;

  assign oe_due     = (state == ST_ACCESS) && (cnt == oe_dly_cyc);
  assign sample_due = (state == ST_ACCESS) && (cnt == acc_cyc);
  assign float_done = (state == ST_FLOAT)  && (cnt == float_cyc);
  assign req_ready  = (state == ST_IDLE) || float_done;
  assign accept     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      grade_q <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else if (accept) begin
      state   <= ST_ACCESS;
      cnt     <= CNT_W'(1);
      addr_q  <= req_addr;
      grade_q <= grade;
      ce_n_q  <= 1'b0;
      oe_n_q  <= 1'b1;
    end else begin
      unique case (state)
        ST_ACCESS: begin
          cnt <= cnt + CNT_W'(1);
          if (oe_due) oe_n_q <= 1'b0;
          if (sample_due) begin
            oe_n_q <= 1'b1;
            ce_n_q <= 1'b1;
            state  <= ST_FLOAT;
            cnt    <= CNT_W'(1);
          end
        end
        ST_FLOAT: begin
          if (float_done) state <= ST_IDLE;
          else            cnt   <= cnt + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_oe_n   = oe_n_q;
  assign capture_en = sample_due;

  // cycles since chip enable went high, saturating (checker state)
  logic [CNT_W-1:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n)               chk_gap <= '1;
    else if (!ce_n_q)         chk_gap <= '0;
    else if (chk_gap != '1)   chk_gap <= chk_gap + CNT_W'(1);
  end

  p_oe_within_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_grade_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(grade_q));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_oe_n);

  p_release_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (mem_oe_n && mem_ce_n));

  p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (chk_gap >= float_cyc - CNT_W'(1)));

endmodule

// File: rtl/eprom_capture.sv
`timescale 1ns/1ps
module eprom_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] mem_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture_en;
      if (capture_en) rsp_data <= mem_data;
    end
  end

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_follows_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> rsp_valid);

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GRADE_W-1:0] grade,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_data
);

  localparam int MAX_CYC = max_cycles(CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [GRADE_W-1:0] grade_q;
  logic [CNT_W-1:0]   oe_dly_cyc;
  logic [CNT_W-1:0]   acc_cyc;
  logic [CNT_W-1:0]   float_cyc;
  logic               capture_en;

  eprom_grade_timing #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .CNT_W         (CNT_W)
  ) u_timing (
    .grade      (grade_q),
    .oe_dly_cyc (oe_dly_cyc),
    .acc_cyc    (acc_cyc),
    .float_cyc  (float_cyc)
  );

  eprom_access_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .grade      (grade),
    .req_ready  (req_ready),
    .oe_dly_cyc (oe_dly_cyc),
    .acc_cyc    (acc_cyc),
    .float_cyc  (float_cyc),
    .grade_q    (grade_q),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .capture_en (capture_en)
  );

  eprom_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .mem_data   (mem_data),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb;

  localparam int PERIOD = 10;
  localparam int WDOG   = 100000;

  int ACC_NS [4] = '{120, 150, 200, 250};
  int OE_NS  [4] = '{50, 60, 70, 100};
  int DF_NS  [4] = '{40, 50, 50, 50};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  grade = 2'd0;
  logic        req_valid = 1'b0;
  logic [16:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_data;

  eprom_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .grade(grade), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected counts, restated from the requirements
  function automatic int cyc_past(input int ns);
    int c = 0;
    while (c * PERIOD <= ns) c++;
    return c;
  endfunction

  function automatic int exp_oe(input int g);
    int k = 0;
    while ((k + 1) * PERIOD <= ACC_NS[g] - OE_NS[g]) k++;
    return (k < 1) ? 1 : k;
  endfunction

  function automatic int exp_acc(input int g);
    int a = cyc_past(ACC_NS[g]);
    int b = exp_oe(g) + cyc_past(OE_NS[g]);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [7:0] rom(input logic [16:0] a);
    return a[7:0] ^ {a[16:13], a[11:8]} ^ 8'hC3;
  endfunction

  // behavioural memory: unknown until every budget has elapsed
  int  m_grade = 0;
  time t_addr = 0, t_ce = 0, t_oe = 0;
  always @(mem_addr)         t_addr = $time;
  always @(negedge mem_ce_n) t_ce   = $time;
  always @(negedge mem_oe_n) t_oe   = $time;
  always begin
    #1;
    if (!mem_ce_n && !mem_oe_n &&
        $time >= t_addr + ACC_NS[m_grade] &&
        $time >= t_ce   + ACC_NS[m_grade] &&
        $time >= t_oe   + OE_NS[m_grade])
      mem_data = rom(mem_addr);
    else
      mem_data = 'x;
  end

  typedef struct {
    logic [16:0] addr;
    int          g;
    int          acc_cyc;
    bit          b2b;
  } item_t;
  item_t sb_q[$];

  task automatic send(input logic [16:0] a, input int g, input bit b2b);
    req_valid = 1'b1;
    req_addr  = a;
    grade     = 2'(g);
    while (req_ready !== 1'b1) @(negedge clk);
    sb_q.push_back('{a, g, cyc + 1, b2b});
    m_grade = g;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;            // R8: must not reach the memory
    grade     = 2'(g + 1);     // R7: must not alter this access
  endtask

  // monitor
  bit          mon_on = 1'b0;
  logic        prev_ce = 1'b1, prev_oe = 1'b1;
  logic [16:0] cur_addr = '0;
  int          cur_start = 0, cur_g = 0;
  bit          addr_bad = 1'b0, have_rise = 1'b0;
  int          last_rise = 0, last_g = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_ce && !mem_ce_n) begin
        if (sb_q.size() > 0) begin
          chk(cyc == sb_q[0].acc_cyc, "R2 chip enable on accept edge",
              cyc, sb_q[0].acc_cyc);
          chk(mem_addr == sb_q[0].addr, "R2 address driven at accept",
              mem_addr, sb_q[0].addr);
          if (have_rise) begin
            if (sb_q[0].b2b)
              chk(cyc - last_rise == cyc_past(DF_NS[last_g]),
                  "R6 back-to-back release gap", cyc - last_rise,
                  cyc_past(DF_NS[last_g]));
            else
              chk(cyc - last_rise >= cyc_past(DF_NS[last_g]),
                  "R6 minimum release gap", cyc - last_rise,
                  cyc_past(DF_NS[last_g]));
          end
          cur_addr  = sb_q[0].addr;
          cur_g     = sb_q[0].g;
        end else begin
          chk(1'b0, "R2 access without request", 1, 0);
        end
        cur_start = cyc;
        addr_bad  = 1'b0;
      end
      if (!mem_ce_n && mem_addr !== cur_addr) addr_bad = 1'b1;
      if (prev_oe && !mem_oe_n) begin
        chk(cyc - cur_start == exp_oe(cur_g), "R4 output enable slot",
            cyc - cur_start, exp_oe(cur_g));
        chk(req_ready == 1'b0, "R2 busy during access", req_ready, 0);
      end
      if (rsp_valid) begin
        if (sb_q.size() > 0) begin
          item_t it;
          it = sb_q.pop_front();
          chk(rsp_data === rom(it.addr), "R5 data", rsp_data, rom(it.addr));
          chk(cyc - it.acc_cyc == exp_acc(it.g), "R3 R7 access latency",
              cyc - it.acc_cyc, exp_acc(it.g));
          chk(mem_oe_n && mem_ce_n, "R5 strobes released at capture",
              {mem_ce_n, mem_oe_n}, 2'b11);
          chk(!addr_bad, "R8 address held through access", addr_bad, 0);
          last_g = it.g;
        end else begin
          chk(1'b0, "R5 response without request", 1, 0);
        end
        last_rise = cyc;
        have_rise = 1'b1;
      end
      prev_ce = mem_ce_n;
      prev_oe = mem_oe_n;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      chk(1'b0, "watchdog expired", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    chk(mem_ce_n === 1'b1, "R1 chip enable idle", mem_ce_n, 1);
    chk(mem_oe_n === 1'b1, "R1 output enable idle", mem_oe_n, 1);
    chk(rsp_valid === 1'b0, "R1 no response", rsp_valid, 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);

    for (int g = 0; g < 4; g++) begin
      send(17'h00000, g, 1'b0);
      repeat (3) @(negedge clk);
      send(17'h1FFFF, g, 1'b0);
      repeat (40) @(negedge clk);
      send(17'(17'h0A5C3 + g * 17'h1357), g, 1'b0);
      for (int k = 0; k < 4; k++)
        send(17'(17'h12345 + k * 17'h0F0F + g), g, k != 0);
      repeat (30) @(negedge clk);
    end

    // bursts that change grade between accesses
    send(17'h00111, 0, 1'b0);
    send(17'h00222, 3, 1'b1);
    send(17'h00333, 1, 1'b1);
    send(17'h00444, 2, 1'b1);
    send(17'h00555, 0, 1'b1);

    repeat (60) @(negedge clk);
    chk(sb_q.size() == 0, "R5 every request answered", sb_q.size(), 0);
    finish_run();
  end

endmodule